// File: doc/BRIEF.md
# Video Blanking and Amplifier Control Decoder

This block turns the horizontal blanking pulse (already corrected to active-high), the overlay fast-blank input, the enhancement window pin and a supply-low flag into the per-cycle decisions of a three-channel video datapath. It combines these inputs with a set of static control bits from a register bank. Its outputs are a blank enable per channel, an overlay insert select, an enhancement active flag with a separate effects enable, an infra-black indent enable with its depth bit, and a 2-bit code that selects one of three levels on an external power amplifier control pin.

Every output is registered on the system clock, so each decision appears one cycle after the inputs that caused it. Standby, whether requested by a control bit or caused by a low supply, overrides all the other decisions. It turns off the datapath enables and drives the amplifier code to its standby value. A separate amplifier-standby bit also selects the standby code, but it leaves the datapath running.

Top module: `vblank_ampctl`

## Requirements
- R1: Each bit of `blank_o` is 1 one cycle after a cycle in which `hblank_i` or `osd_fb_i` is 1, or in which both `cfg_sw_blank_i` and `cfg_blank_arm_i` are 1. Otherwise it is 0. All channels carry the same value.
- R2: Software blanking needs both bits. If only one of `cfg_sw_blank_i` and `cfg_blank_arm_i` is 1, and `hblank_i` and `osd_fb_i` are 0, then `blank_o` stays all zero.
- R3: `boost_o` is 1 one cycle after `cfg_boost_gen_i` is 1 together with `boost_pin_i` or `cfg_boost_force_i`, and the device is not in standby.
- R4: `boost_fx_o` is 1 only when the R3 condition holds and `cfg_boost_fx_i` is also 1.
- R5: `osd_sel_o` follows `osd_fb_i` one cycle later, and it is forced to 0 during device standby.
- R6: `ipulse_en_o` follows `hblank_i` one cycle later, and it is forced to 0 during device standby. `ipulse_deep_o` carries `cfg_pulse_deep_i` one cycle later: 0 selects the shallow indent and 1 selects the deep indent.
- R7: Device standby is in force when `cfg_pre_stby_i` or `vsup_low_i` is 1. One cycle later, `amp_lvl_o` is 2'b00 (standby).
- R8: When `cfg_amp_stby_i` is 1, `amp_lvl_o` is 2'b00 one cycle later, whatever the value of `cfg_amp_blank_i`.
- R9: Outside both standby conditions, `amp_lvl_o` is 2'b01 (blanking level) one cycle after `cfg_amp_blank_i` and `hblank_i` are both 1. In every other case it is 2'b10 (high level).
- R10: While the synchronous active-high `rst` is held, all outputs are 0 and `amp_lvl_o` is 2'b00.
- R11: `amp_lvl_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank_i | input | 1 | Corrected horizontal blanking pulse, active high |
| osd_fb_i | input | 1 | Overlay fast-blank input |
| boost_pin_i | input | 1 | Enhancement window pin |
| vsup_low_i | input | 1 | Output supply below threshold |
| cfg_sw_blank_i | input | 1 | Software blank request |
| cfg_blank_arm_i | input | 1 | Second key bit for software blank |
| cfg_boost_gen_i | input | 1 | Enhancement general enable |
| cfg_boost_force_i | input | 1 | Enhancement over the whole screen |
| cfg_boost_fx_i | input | 1 | Enhancement peaking/offset enable |
| cfg_pulse_deep_i | input | 1 | Indent depth: 0 shallow, 1 deep |
| cfg_pre_stby_i | input | 1 | Device standby request |
| cfg_amp_stby_i | input | 1 | Amplifier standby request |
| cfg_amp_blank_i | input | 1 | Amplifier blanking level enable |
| blank_o | output | NCH | Per-channel blank enable |
| osd_sel_o | output | 1 | Overlay insert select |
| boost_o | output | 1 | Enhancement active |
| boost_fx_o | output | 1 | Enhancement effects active |
| ipulse_en_o | output | 1 | Infra-black indent enable |
| ipulse_deep_o | output | 1 | Indent depth select |
| amp_lvl_o | output | 2 | Amplifier control code |

## Verification
The bench goes after the priority corners. The first is software blanking with only one of its two bits set: a design that decoded a single bit would blank the screen. The second is an amplifier-standby request with the blanking enable on during a blank pulse: a design that checked the blanking enable first would emit 2'b01 where 2'b00 is due. Supply-low standby is applied with every datapath enable requested, so a design that left an enable ungated would show overlay or enhancement during standby. The bench also checks the one-cycle latency of every output, and it checks that the forced-enhancement bit has no effect without the general enable.

// File: rtl/vbac_pkg.sv
package vbac_pkg;
  localparam int AMP_W = 2;

  typedef enum logic [AMP_W-1:0] {
    AMP_STBY  = 2'b00,
    AMP_BLANK = 2'b01,
    AMP_HIGH  = 2'b10
  } amp_lvl_e;
endpackage

// File: rtl/vbac_stby_dec.sv
module vbac_stby_dec (
  input  logic cfg_pre_stby_i,
  input  logic vsup_low_i,
  output logic dev_stby_o
);
  always_comb begin
    dev_stby_o = cfg_pre_stby_i | vsup_low_i;
  end
endmodule

// File: rtl/vbac_blank_gen.sv
module vbac_blank_gen #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hblank_i,
  input  logic           osd_fb_i,
  input  logic           cfg_sw_blank_i,
  input  logic           cfg_blank_arm_i,
  output logic [NCH-1:0] blank_o
);
  logic sw_blank;
  logic any_blank;

  always_comb begin
    sw_blank  = cfg_sw_blank_i & cfg_blank_arm_i;
    any_blank = hblank_i | osd_fb_i | sw_blank;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) blank_o[ch] <= 1'b0;
      else     blank_o[ch] <= any_blank;
    end
  end
endmodule

// File: rtl/vbac_path_en.sv
module vbac_path_en (
  input  logic clk,
  input  logic rst,
  input  logic dev_stby_i,
  input  logic hblank_i,
  input  logic osd_fb_i,
  input  logic boost_pin_i,
  input  logic cfg_boost_gen_i,
  input  logic cfg_boost_force_i,
  input  logic cfg_boost_fx_i,
  input  logic cfg_pulse_deep_i,
  output logic osd_sel_o,
  output logic boost_o,
  output logic boost_fx_o,
  output logic ipulse_en_o,
  output logic ipulse_deep_o
);
  logic run;
  logic boost_req;

  always_comb begin
    run       = ~dev_stby_i;
    boost_req = cfg_boost_gen_i & (boost_pin_i | cfg_boost_force_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osd_sel_o     <= 1'b0;
      boost_o       <= 1'b0;
      boost_fx_o    <= 1'b0;
      ipulse_en_o   <= 1'b0;
      ipulse_deep_o <= 1'b0;
    end else begin
      osd_sel_o     <= run & osd_fb_i;
      boost_o       <= run & boost_req;
      boost_fx_o    <= run & boost_req & cfg_boost_fx_i;
      ipulse_en_o   <= run & hblank_i;
      ipulse_deep_o <= cfg_pulse_deep_i;
    end
  end
endmodule

// File: rtl/vbac_amp_enc.sv
module vbac_amp_enc
  import vbac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_stby_i,
  input  logic             hblank_i,
  input  logic             cfg_amp_stby_i,
  input  logic             cfg_amp_blank_i,
  output logic [AMP_W-1:0] amp_lvl_o
);
  amp_lvl_e nxt;

  always_comb begin
    if (dev_stby_i || cfg_amp_stby_i)       nxt = AMP_STBY;
    else if (cfg_amp_blank_i && hblank_i)   nxt = AMP_BLANK;
    else                                    nxt = AMP_HIGH;
  end

  always_ff @(posedge clk) begin
    if (rst) amp_lvl_o <= AMP_STBY;
    else     amp_lvl_o <= nxt;
  end
endmodule

// File: rtl/vblank_ampctl.sv
module vblank_ampctl
  import vbac_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hblank_i,
  input  logic             osd_fb_i,
  input  logic             boost_pin_i,
  input  logic             vsup_low_i,
  input  logic             cfg_sw_blank_i,
  input  logic             cfg_blank_arm_i,
  input  logic             cfg_boost_gen_i,
  input  logic             cfg_boost_force_i,
  input  logic             cfg_boost_fx_i,
  input  logic             cfg_pulse_deep_i,
  input  logic             cfg_pre_stby_i,
  input  logic             cfg_amp_stby_i,
  input  logic             cfg_amp_blank_i,
  output logic [NCH-1:0]   blank_o,
  output logic             osd_sel_o,
  output logic             boost_o,
  output logic             boost_fx_o,
  output logic             ipulse_en_o,
  output logic             ipulse_deep_o,
  output logic [AMP_W-1:0] amp_lvl_o
);
  logic dev_stby;

  vbac_stby_dec u_stby (
    .cfg_pre_stby_i (cfg_pre_stby_i),
    .vsup_low_i     (vsup_low_i),
    .dev_stby_o     (dev_stby)
  );

  vbac_blank_gen #(.NCH(NCH)) u_blank (
    .clk             (clk),
    .rst             (rst),
    .hblank_i        (hblank_i),
    .osd_fb_i        (osd_fb_i),
    .cfg_sw_blank_i  (cfg_sw_blank_i),
    .cfg_blank_arm_i (cfg_blank_arm_i),
    .blank_o         (blank_o)
  );

  vbac_path_en u_path (
    .clk               (clk),
    .rst               (rst),
    .dev_stby_i        (dev_stby),
    .hblank_i          (hblank_i),
    .osd_fb_i          (osd_fb_i),
    .boost_pin_i       (boost_pin_i),
    .cfg_boost_gen_i   (cfg_boost_gen_i),
    .cfg_boost_force_i (cfg_boost_force_i),
    .cfg_boost_fx_i    (cfg_boost_fx_i),
    .cfg_pulse_deep_i  (cfg_pulse_deep_i),
    .osd_sel_o         (osd_sel_o),
    .boost_o           (boost_o),
    .boost_fx_o        (boost_fx_o),
    .ipulse_en_o       (ipulse_en_o),
    .ipulse_deep_o     (ipulse_deep_o)
  );

  vbac_amp_enc u_amp (
    .clk             (clk),
    .rst             (rst),
    .dev_stby_i      (dev_stby),
    .hblank_i        (hblank_i),
    .cfg_amp_stby_i  (cfg_amp_stby_i),
    .cfg_amp_blank_i (cfg_amp_blank_i),
    .amp_lvl_o       (amp_lvl_o)
  );
endmodule

// File: rtl/vbac_checker.sv
module vbac_checker #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           hblank_i,
  input logic           osd_fb_i,
  input logic           boost_pin_i,
  input logic           vsup_low_i,
  input logic           cfg_sw_blank_i,
  input logic           cfg_blank_arm_i,
  input logic           cfg_boost_gen_i,
  input logic           cfg_boost_force_i,
  input logic           cfg_boost_fx_i,
  input logic           cfg_pulse_deep_i,
  input logic           cfg_pre_stby_i,
  input logic           cfg_amp_stby_i,
  input logic           cfg_amp_blank_i,
  input logic [NCH-1:0] blank_o,
  input logic           osd_sel_o,
  input logic           boost_o,
  input logic           boost_fx_o,
  input logic           ipulse_en_o,
  input logic           ipulse_deep_o,
  input logic [1:0]     amp_lvl_o
);
  a_r1_blank_any: assert property (@(posedge clk) disable iff (rst)
    (hblank_i || osd_fb_i) |=> (blank_o == {NCH{1'b1}}));

  a_r2_sw_single_bit: assert property (@(posedge clk) disable iff (rst)
    (!hblank_i && !osd_fb_i && !(cfg_sw_blank_i && cfg_blank_arm_i)) |=> (blank_o == '0));

  a_r3_boost_off_no_gen: assert property (@(posedge clk) disable iff (rst)
    !cfg_boost_gen_i |=> !boost_o);

  a_r4_fx_needs_boost: assert property (@(posedge clk) disable iff (rst)
    boost_fx_o |-> boost_o);

  a_r5_osd_follow: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pre_stby_i && !vsup_low_i) |=> (osd_sel_o == $past(osd_fb_i)));

  a_r6_depth_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ipulse_deep_o == $past(cfg_pulse_deep_i)));

  a_r7_dev_stby: assert property (@(posedge clk) disable iff (rst)
    (cfg_pre_stby_i || vsup_low_i) |=> (amp_lvl_o == 2'b00 && !boost_o && !osd_sel_o && !ipulse_en_o));

  a_r8_amp_stby: assert property (@(posedge clk) disable iff (rst)
    cfg_amp_stby_i |=> (amp_lvl_o == 2'b00));

  a_r9_blank_level: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pre_stby_i && !vsup_low_i && !cfg_amp_stby_i && cfg_amp_blank_i && hblank_i) |=> (amp_lvl_o == 2'b01));

  a_r11_no_code3: assert property (@(posedge clk) disable iff (rst)
    amp_lvl_o != 2'b11);
endmodule

bind vblank_ampctl vbac_checker #(.NCH(NCH)) chk_i (.*);

// File: tb/vblank_ampctl_tb_top.sv
module vblank_ampctl_tb_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] s = '0;
  logic [NCH-1:0] blank_o;
  logic osd_sel_o, boost_o, boost_fx_o, ipulse_en_o, ipulse_deep_o;
  logic [1:0] amp_lvl_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vblank_ampctl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst),
    .hblank_i(s[0]), .osd_fb_i(s[1]), .boost_pin_i(s[2]), .vsup_low_i(s[3]),
    .cfg_sw_blank_i(s[4]), .cfg_blank_arm_i(s[5]), .cfg_boost_gen_i(s[6]),
    .cfg_boost_force_i(s[7]), .cfg_boost_fx_i(s[8]), .cfg_pulse_deep_i(s[9]),
    .cfg_pre_stby_i(s[10]), .cfg_amp_stby_i(s[11]), .cfg_amp_blank_i(s[12]),
    .blank_o(blank_o), .osd_sel_o(osd_sel_o), .boost_o(boost_o),
    .boost_fx_o(boost_fx_o), .ipulse_en_o(ipulse_en_o),
    .ipulse_deep_o(ipulse_deep_o), .amp_lvl_o(amp_lvl_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_stby(input logic [12:0] v);
    return v[10] | v[3];
  endfunction
  function automatic logic exp_boost(input logic [12:0] v);
    return v[6] & (v[2] | v[7]) & ~exp_stby(v);
  endfunction
  function automatic logic [1:0] exp_amp(input logic [12:0] v);
    if (exp_stby(v) || v[11]) return 2'b00;
    if (v[12] && v[0]) return 2'b01;
    return 2'b10;
  endfunction

  task automatic step(input logic [12:0] v);
    logic blk;
    s = v;
    @(negedge clk);
    blk = v[0] | v[1] | (v[4] & v[5]);
    chk("R1 R2 blank", {1'b0, blank_o}, {1'b0, {NCH{blk}}});
    chk("R3 boost", {3'b0, boost_o}, {3'b0, exp_boost(v)});
    chk("R4 boost fx", {3'b0, boost_fx_o}, {3'b0, exp_boost(v) & v[8]});
    chk("R5 osd sel", {3'b0, osd_sel_o}, {3'b0, v[1] & ~exp_stby(v)});
    chk("R6 pulse en", {3'b0, ipulse_en_o}, {3'b0, v[0] & ~exp_stby(v)});
    chk("R6 pulse depth", {3'b0, ipulse_deep_o}, {3'b0, v[9]});
    chk("R7 R8 R9 amp code", {2'b0, amp_lvl_o}, {2'b0, exp_amp(v)});
    chk("R11 amp not 3", {3'b0, amp_lvl_o == 2'b11}, 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    s = 13'h1fff;
    repeat (3) @(negedge clk);
    // R10: reset state, all outputs zero and standby code
    chk("R10 reset blank", {1'b0, blank_o}, 4'h0);
    chk("R10 reset flags", {osd_sel_o, boost_o, boost_fx_o, ipulse_en_o}, 4'h0);
    chk("R10 reset depth/amp", {1'b0, ipulse_deep_o, amp_lvl_o}, 4'h0);
    rst = 1'b0;
    // R2: each software blank bit alone, then both (R1)
    step(13'b0_0000_0001_0000);
    step(13'b0_0000_0010_0000);
    step(13'b0_0000_0011_0000);
    // R3: force bit without general enable, then with it; pin route
    step(13'b0_0000_1000_0000);
    step(13'b0_0000_1100_0000);
    step(13'b0_0001_0100_0100);
    // R8: amp standby beats blanking enable during blank pulse
    step(13'b1_1000_0000_0001);
    // R9: blanking level, high otherwise, enable off keeps high
    step(13'b1_0000_0000_0001);
    step(13'b1_0000_0000_0000);
    step(13'b0_0000_0000_0001);
    // R7: supply low and pre-standby with everything requested
    step(13'b1_0011_1100_1111);
    step(13'b1_0111_1100_0111);
    // R6 depth both values
    step(13'b0_0010_0000_0001);
    for (int i = 0; i < 400; i++) begin
      logic [12:0] v;
      v = 13'($urandom);
      if (($urandom % 4) != 0) begin
        v[3] = 1'b0;
        v[10] = 1'b0;
      end
      if (($urandom % 3) != 0) v[11] = 1'b0;
      step(v);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule